// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper Registers

This block sits between a USB dual-role controller core and a CPU. It collects per-endpoint and core-level interrupt events into two groups of 32-bit registers. Each group holds a raw source word, a mask word and a read-only masked view. Software never writes the source or mask words directly. It uses separate write-one-to-set and write-one-to-clear alias addresses, so no read-modify-write is needed. The endpoint word carries transmit endpoints 0 to 15 in bits 15:0 and receive endpoints 1 to 15 in bits 31:17.

A single interrupt line to the CPU fires as a one-cycle pulse when any masked bit is pending. It then stays quiet, whatever arrives, until software writes the end-of-interrupt address. The block also has a nonzero revision word, a control word whose bit 0 wipes all source and mask state, and a status word that shows the VBUS-drive level coming from the transceiver.

Top module: `usb_irq_wrap`

## Requirements
- R1: Offset 0x00 reads the parameter REV_ID, default 32'h0001_0A03, which is nonzero.
- R2: Offset 0x08 reads vbus_drv in bit 0 and zero in every other bit. Offset 0x04 always reads zero.
- R3: In the endpoint group, source (0x20) and mask (0x2C) place ep_evt bits 15:0 and 31:17 at the same positions. Bit 16 always reads 0.
- R4: In the core group, core_evt[8:0] sets source (0x40) bits 24:16. The VBUS-drive event core_evt[8] lands at bit 24. Bits outside 24:16 of core source and core mask (0x4C) always read 0.
- R5: A write to a set alias sets each source or mask bit whose written bit is 1 and leaves the others unchanged. The set aliases are endpoint source 0x24, endpoint mask 0x30, core source 0x44 and core mask 0x50.
- R6: A write to a clear alias clears each bit whose written bit is 1 and leaves the others unchanged. The clear aliases are endpoint source 0x28, endpoint mask 0x34, core source 0x48 and core mask 0x54.
- R7: Offsets 0x38 and 0x58 read the bitwise AND of their group's source and mask.
- R8: An event input bit sets its source bit at the next clock edge. This holds even when a clear write to that bit happens in the same cycle, so the event wins.
- R9: irq_out is a single-cycle pulse. It is raised in the cycle after a cycle in which the line is armed and either masked word is nonzero. Firing disarms the line.
- R10: A write of any value to 0x60 re-arms the line. The earliest new pulse comes two cycles after the write cycle. No pulse occurs between a pulse and the next such write.
- R11: A control write (0x04) with bit 0 set clears all source and mask bits of both groups at the next edge. This includes events arriving in that same cycle. A control write with bit 0 clear changes nothing.
- R12: Offsets 0x10 and 0x5C, all alias addresses, 0x60, misaligned addresses and offsets above 0x60 read zero. Writes to 0x00, 0x08, 0x20, 0x2C, 0x38, 0x40, 0x4C and 0x58 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset for the read and the write |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ep_evt | input | 32 | Endpoint event pulses, same bit layout as the endpoint word |
| core_evt | input | 9 | Core event pulses, bit 8 is the VBUS-drive event |
| vbus_drv | input | 1 | VBUS-drive level from the transceiver |
| irq_out | output | 1 | Interrupt pulse to the CPU |

## Verification
The hardest situations to reach are those where two things collide in one cycle. One is an event arriving on the same bit as a clear write. Another is an event arriving together with the soft-reset write. A third is pending work that is still present when the end-of-interrupt write lands. The stimulus drives events and register writes in the very same cycle for each of these collisions. After a pulse, it leaves sources pending while fresh events keep arriving, to show that the line stays silent until the end-of-interrupt write. A behavioural model updated on every edge predicts every read word and the interrupt line across all of these cases.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int unsigned DATA_W       = 32;
    localparam int unsigned CORE_EVT_W   = 9;
    localparam int unsigned CORE_EVT_LSB = 16;

    // fixed offsets
    localparam logic [7:0] OFF_REV  = 8'h00;
    localparam logic [7:0] OFF_CTRL = 8'h04;
    localparam logic [7:0] OFF_STAT = 8'h08;
    localparam logic [7:0] OFF_EOI  = 8'h60;

    // group bases and offsets inside a group
    localparam logic [7:0] BASE_EP   = 8'h20;
    localparam logic [7:0] BASE_CORE = 8'h40;
    localparam logic [7:0] SUB_SRC     = 8'h00;
    localparam logic [7:0] SUB_SRC_SET = 8'h04;
    localparam logic [7:0] SUB_SRC_CLR = 8'h08;
    localparam logic [7:0] SUB_MSK     = 8'h0C;
    localparam logic [7:0] SUB_MSK_SET = 8'h10;
    localparam logic [7:0] SUB_MSK_CLR = 8'h14;
    localparam logic [7:0] SUB_MASKED  = 8'h18;

    localparam logic [DATA_W-1:0] EP_VALID   = 32'hFFFE_FFFF;
    localparam logic [DATA_W-1:0] CORE_VALID = 32'h01FF_0000;

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] msk;
    } grp_state_t;

    typedef struct packed {
        logic armed;
        logic fire;
    } arm_state_t;

endpackage

// File: rtl/usb_irq_group.sv
module usb_irq_group
    import usb_irq_pkg::*;
#(
    parameter int unsigned       W     = DATA_W,
    parameter logic [W-1:0]      VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic [W-1:0] set_src,
    input  logic [W-1:0] clr_src,
    input  logic [W-1:0] set_msk,
    input  logic [W-1:0] clr_msk,
    input  logic [W-1:0] hw_evt,
    output logic [W-1:0] src_o,
    output logic [W-1:0] msk_o,
    output logic [W-1:0] masked_o
);

    typedef struct packed {
        logic [W-1:0] src;
        logic [W-1:0] msk;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_clr) begin
            st_d = '0;
        end else begin
            // event OR'd in after the clear: events are never lost
            st_d.src = ((st_q.src & ~clr_src) | set_src | hw_evt) & VALID;
            st_d.msk = ((st_q.msk & ~clr_msk) | set_msk) & VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_o    = st_q.src;
    assign msk_o    = st_q.msk;
    assign masked_o = st_q.src & st_q.msk;

endmodule

// File: rtl/usb_irq_arm.sv
module usb_irq_arm
    import usb_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic eoi,
    output logic irq
);

    arm_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = st_q.armed & pend;
        if (st_d.fire)  st_d.armed = 1'b0;
        else if (eoi)   st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b1, fire: 1'b0};
        else        st_q <= st_d;
    end

    assign irq = st_q.fire;

endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
    import usb_irq_pkg::*;
#(
    parameter int unsigned       ADDR_W = 8,
    parameter logic [DATA_W-1:0] REV_ID = 32'h0001_0A03
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [DATA_W-1:0]     ep_evt,
    input  logic [CORE_EVT_W-1:0] core_evt,
    input  logic                  vbus_drv,
    output logic                  irq_out
);

    localparam int unsigned NGRP = 2;

    function automatic logic [7:0] grp_base(input int g);
        return (g == 0) ? BASE_EP : BASE_CORE;
    endfunction

    function automatic logic [ADDR_W-1:0] reg_at(input logic [7:0] base, input logic [7:0] sub);
        return ADDR_W'(base) + ADDR_W'(sub);
    endfunction

    logic [NGRP-1:0][DATA_W-1:0] grp_set_src, grp_clr_src, grp_set_msk, grp_clr_msk;
    logic [NGRP-1:0][DATA_W-1:0] grp_evt, grp_src, grp_msk, grp_masked;
    logic soft_clr, eoi_wr, any_pend;

    assign soft_clr = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[0];
    assign eoi_wr   = bus_wr && (bus_addr == ADDR_W'(OFF_EOI));

    assign grp_evt[0] = ep_evt;
    assign grp_evt[1] = DATA_W'(core_evt) << CORE_EVT_LSB;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam logic [7:0]        BASE  = (g == 0) ? BASE_EP : BASE_CORE;
        localparam logic [DATA_W-1:0] VALID = (g == 0) ? EP_VALID : CORE_VALID;

        assign grp_set_src[g] = (bus_wr && bus_addr == reg_at(BASE, SUB_SRC_SET)) ? bus_wdata : '0;
        assign grp_clr_src[g] = (bus_wr && bus_addr == reg_at(BASE, SUB_SRC_CLR)) ? bus_wdata : '0;
        assign grp_set_msk[g] = (bus_wr && bus_addr == reg_at(BASE, SUB_MSK_SET)) ? bus_wdata : '0;
        assign grp_clr_msk[g] = (bus_wr && bus_addr == reg_at(BASE, SUB_MSK_CLR)) ? bus_wdata : '0;

        usb_irq_group #(.W(DATA_W), .VALID(VALID)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_clr),
            .set_src  (grp_set_src[g]),
            .clr_src  (grp_clr_src[g]),
            .set_msk  (grp_set_msk[g]),
            .clr_msk  (grp_clr_msk[g]),
            .hw_evt   (grp_evt[g]),
            .src_o    (grp_src[g]),
            .msk_o    (grp_msk[g]),
            .masked_o (grp_masked[g])
        );
    end

    assign any_pend = |grp_masked;

    usb_irq_arm u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (any_pend),
        .eoi   (eoi_wr),
        .irq   (irq_out)
    );

    // read mux: anything not listed reads zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_REV))  bus_rdata = REV_ID;
        if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = DATA_W'(vbus_drv);
        for (int g = 0; g < NGRP; g++) begin
            if (bus_addr == reg_at(grp_base(g), SUB_SRC))    bus_rdata = grp_src[g];
            if (bus_addr == reg_at(grp_base(g), SUB_MSK))    bus_rdata = grp_msk[g];
            if (bus_addr == reg_at(grp_base(g), SUB_MASKED)) bus_rdata = grp_masked[g];
        end
    end

endmodule

// File: rtl/usb_irq_wrap_chk.sv
module usb_irq_wrap_chk
    import usb_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     ep_evt,
    input logic                  irq_out,
    input logic [DATA_W-1:0]     ep_src,
    input logic [DATA_W-1:0]     ep_msk,
    input logic [DATA_W-1:0]     core_src,
    input logic [DATA_W-1:0]     core_msk
);

    logic soft_w, fired_q;
    assign soft_w = bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[0];

    // set on a pulse, cleared by an end-of-interrupt write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        fired_q <= 1'b0;
        else if (bus_wr && bus_addr == ADDR_W'(OFF_EOI))   fired_q <= 1'b0;
        else if (irq_out)                                  fired_q <= 1'b1;
    end

    a_r3_bit16_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_src[16] && !ep_msk[16]);

    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_w && ep_evt != '0) |=>
        ((ep_src & $past(ep_evt & EP_VALID)) == $past(ep_evt & EP_VALID)));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |=> !irq_out);

    a_r9_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(((ep_src & ep_msk) | (core_src & core_msk)) != '0));

    a_r10_quiet_till_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> !fired_q);

    a_r11_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_w |=> (ep_src == '0 && ep_msk == '0 && core_src == '0 && core_msk == '0));

endmodule

bind usb_irq_wrap usb_irq_wrap_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .ep_evt    (ep_evt),
    .irq_out   (irq_out),
    .ep_src    (grp_src[0]),
    .ep_msk    (grp_msk[0]),
    .core_src  (grp_src[1]),
    .core_msk  (grp_msk[1])
);

// File: tb/sim_usb_irq_wrap.sv
module sim_usb_irq_wrap;

    localparam logic [31:0] REV = 32'h0001_0A03;
    localparam logic [31:0] EPV = 32'hFFFE_FFFF;
    localparam logic [31:0] COV = 32'h01FF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ep_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        vbus_drv = 1'b0;
    logic        irq_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_eps = '0, m_epm = '0, m_cos = '0, m_com = '0;
    bit          m_armed = 1, m_irq = 0;

    always #2 clk = ~clk;

    usb_irq_wrap u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_evt(ep_evt),
        .core_evt(core_evt), .vbus_drv(vbus_drv), .irq_out(irq_out)
    );

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return REV;
            8'h08: return {31'b0, vbus_drv};
            8'h20: return m_eps;
            8'h2C: return m_epm;
            8'h38: return m_eps & m_epm;
            8'h40: return m_cos;
            8'h4C: return m_com;
            8'h58: return m_cos & m_com;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        case (a)
            8'h00: return "R1";
            8'h04, 8'h08: return "R2";
            8'h20, 8'h2C: return "R3";
            8'h40, 8'h4C: return "R4";
            8'h38, 8'h58: return "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive, compare against model, advance model at the edge
    task automatic cyc(input logic [7:0] a, input bit w, input logic [31:0] d,
                       input logic [31:0] ep, input logic [8:0] co);
        bit fire;
        logic [31:0] cw;
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d; ep_evt = ep; core_evt = co;
        #1;
        chk($sformatf("%s read@%h (R5 R6 R8 R11 via state)", req_of(a), a), bus_rdata, m_read(a));
        chk("R9 R10 irq_out", {31'b0, irq_out}, {31'b0, m_irq});
        @(posedge clk);
        fire = m_armed && (((m_eps & m_epm) | (m_cos & m_com)) != 0);
        cw = {7'b0, co, 16'b0};
        if (w && a == 8'h04 && d[0]) begin
            m_eps = 0; m_epm = 0; m_cos = 0; m_com = 0;
        end else begin
            if (w && a == 8'h28) m_eps = m_eps & ~d;
            if (w && a == 8'h24) m_eps = m_eps | d;
            m_eps = (m_eps | ep) & EPV;
            if (w && a == 8'h34) m_epm = m_epm & ~d;
            if (w && a == 8'h30) m_epm = (m_epm | d) & EPV;
            if (w && a == 8'h48) m_cos = m_cos & ~d;
            if (w && a == 8'h44) m_cos = m_cos | d;
            m_cos = (m_cos | cw) & COV;
            if (w && a == 8'h54) m_com = m_com & ~d;
            if (w && a == 8'h50) m_com = (m_com | d) & COV;
        end
        m_irq = fire;
        if (fire) m_armed = 0;
        else if (w && a == 8'h60) m_armed = 1;
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(a, 0, 0, 0, 0);
    endtask

    task automatic sweep();
        for (int o = 0; o <= 8'h68; o += 4) rd(8'(o));
        rd(8'h21);
        rd(8'h7C);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state (R1 R2 R12)
        sweep();

        // R2 status follows vbus_drv
        vbus_drv = 1; rd(8'h08);
        vbus_drv = 0; rd(8'h08);

        // R3 R5: set all endpoint mask bits, bit 16 stays 0
        cyc(8'h30, 1, 32'hFFFF_FFFF, 0, 0);
        rd(8'h2C);
        // R3 R8 R9: events including unused bit 16
        cyc(8'h38, 0, 0, 32'h0001_0001, 0);
        rd(8'h38); rd(8'h20); rd(8'h38);
        // R10: more events while disarmed, line quiet
        cyc(8'h20, 0, 0, 32'h8000_0000, 0);
        repeat (4) rd(8'h38);
        // R10: EOI with pending work fires again
        cyc(8'h60, 1, 32'h1234_5678, 0, 0);
        repeat (4) rd(8'h20);

        // R6 R8: clear all with a same-cycle event on bit 2
        cyc(8'h28, 1, 32'hFFFF_FFFF, 32'h0000_0004, 0);
        rd(8'h20);
        // R6: clear mask bit 2 only, no pending left
        cyc(8'h34, 1, 32'h0000_0004, 0, 0);
        rd(8'h2C); rd(8'h38);
        cyc(8'h60, 1, 0, 0, 0);
        repeat (3) rd(8'h38);

        // R4 R5: core mask, VBUS-drive event at bit 24
        cyc(8'h50, 1, 32'hFFFF_FFFF, 0, 0);
        rd(8'h4C);
        cyc(8'h40, 0, 0, 0, 9'h100);
        rd(8'h40); rd(8'h58); rd(8'h58);
        cyc(8'h60, 1, 0, 0, 9'h001);
        repeat (3) rd(8'h58);
        // R8 on core: clear with same-cycle event
        cyc(8'h48, 1, 32'hFFFF_FFFF, 0, 9'h010);
        rd(8'h40);

        // R12: writes to read-only or reserved addresses are ignored
        cyc(8'h20, 1, 32'hFFFF_FFFF, 0, 0);
        cyc(8'h2C, 1, 32'h0, 0, 0);
        cyc(8'h40, 1, 32'hFFFF_FFFF, 0, 0);
        cyc(8'h4C, 1, 32'h0, 0, 0);
        cyc(8'h00, 1, 32'h0, 0, 0);
        cyc(8'h10, 1, 32'hFFFF_FFFF, 0, 0);
        cyc(8'h38, 1, 32'hFFFF_FFFF, 0, 0);
        sweep();

        // R5 R6 partial set/clear of endpoint source
        cyc(8'h24, 1, 32'h0000_00F0, 0, 0);
        rd(8'h20);
        cyc(8'h28, 1, 32'h0000_0010, 0, 0);
        rd(8'h20);
        cyc(8'h44, 1, 32'h0105_0000, 0, 0);
        rd(8'h40);

        // R11: control write without bit 0 does nothing
        cyc(8'h04, 1, 32'hFFFF_FFFE, 0, 0);
        sweep();
        // R11: soft reset with same-cycle events
        cyc(8'h04, 1, 32'h0000_0001, 32'hFFFF_FFFF, 9'h1FF);
        sweep();
        cyc(8'h60, 1, 0, 0, 0);
        repeat (3) rd(8'h38);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog R1..R12 act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule